// File: doc/BRIEF.md
# Two-Level Successor Address Cache

This block sits beside a front end that fetches several basic blocks per cycle. The branch target buffer supplies the fetch address of the current group. The block uses that address to look up a small direct-mapped table. Each line of the table describes the branches that may end the current group and the group after it. Each line holds a 23-bit tag, three branch descriptors of three bits each, and six 30-bit successor addresses, 212 bits of payload in total. Two successors belong to the first branch, one per outcome. The other four are the addresses reached after two branches: taken-taken, taken-not, not-taken, not-not.

The pattern history table is outside the block. It delivers a primary and a secondary direction prediction. With these the block returns two addresses in the same cycle: the start of the next block and the start of the block after that. Branch descriptors that are invalid or unconditional change how the prediction bits are used. When the tag misses, only sequential addresses come out. A write port fills whole lines once branches resolve.

A small controller has two states. `ST_SWEEP` is entered on reset. In it the controller walks every line and clears its valid flag, one line per cycle. The transition `SWEEP_DONE` moves it to `ST_SERVE` after the last line is cleared. `ST_SERVE` holds until the next reset.

Top module: `succ_path_cache`

## Requirements
- R1: After reset the block stays in the sweep state for 2^IDX_W cycles (16 by default). During the sweep every lookup misses and every write is dropped, so a line written during the sweep still misses afterwards.
- R2: The line index is `lk_addr[OFS_W +: IDX_W]` (bits 6:3 by default) and the tag is the top TAG_W bits (29:7). A lookup hits only when the indexed line is valid and its tag equals the lookup tag. The offset bits (2:0) play no part in matching.
- R3: On a miss `lk_hit` is 0, `lk_next1` is `lk_addr + SEQ_STEP` and `lk_next2` is `lk_addr + 2*SEQ_STEP`, both modulo 2^ADDR_W (SEQ_STEP = 4 by default).
- R4: On a hit where slot 0 (the first branch) is valid and conditional (kind 2'b00), `lk_next1` is the taken target when `lk_pred1`=1 and the not-taken target when `lk_pred1`=0.
- R5: When slot 0 is valid with kind 2'b01 (unconditional) or 2'b10 (return), `lk_next1` is the taken target whatever `lk_pred1` is.
- R6: When slot 0 is invalid on a hit, `lk_next1` is `lk_addr + SEQ_STEP` and the first level counts as not taken.
- R7: The second branch comes from slot 1 when the first level was taken and from slot 2 otherwise. With that slot valid and conditional, the pair {first direction, `lk_pred2`} selects the taken-taken, taken-not, not-taken or not-not address for `lk_next2`.
- R8: When the selected second slot has kind 2'b01 or 2'b10, the second level is taken whatever `lk_pred2` is.
- R9: When the selected second slot is invalid, `lk_next2` is `lk_next1 + SEQ_STEP`.
- R10: A write in the serve state replaces the whole line, tag included, and becomes visible to lookups from the next cycle. A lookup in the same cycle as a write to its line sees the old contents.
- R11: Kind 2'b11 behaves as a conditional branch at either level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the sweep |
| lk_addr | input | ADDR_W | Fetch address from the target buffer |
| lk_pred1 | input | 1 | Primary direction prediction (1 = taken) |
| lk_pred2 | input | 1 | Secondary direction prediction (1 = taken) |
| lk_hit | output | 1 | Line valid and tag matched |
| lk_next1 | output | ADDR_W | Fetch address of the next basic block |
| lk_next2 | output | ADDR_W | Fetch address of the block after that |
| wr_en | input | 1 | Write a whole line |
| wr_line | input | ADDR_W-OFS_W | Tag and index of the line to write |
| wr_slot_vld | input | 3 | Valid bit per branch slot (0 first, 1 after taken, 2 after not-taken) |
| wr_slot_kind | input | 6 | Two kind bits per slot, slot k in bits 2k+1:2k |
| wr_tgt_t | input | ADDR_W | First branch taken target |
| wr_tgt_n | input | ADDR_W | First branch not-taken target |
| wr_tgt_tt | input | ADDR_W | Address after taken, taken |
| wr_tgt_tn | input | ADDR_W | Address after taken, not taken |
| wr_tgt_nt | input | ADDR_W | Address after not taken, taken |
| wr_tgt_nn | input | ADDR_W | Address after not taken, not taken |

## Verification
A lookup and a fill of the same line can land in the same cycle. Only the ordering of old and new contents decides the result. The bench provokes this by presenting a write and a lookup to one line at the same falling edge. It expects the old successors before the following rising edge and the new ones right after it. A fill during the sweep competes with the line clearing, so the bench writes a line the sweep has already passed and expects that line to miss once serving begins.

// File: rtl/spc_pkg.sv
package spc_pkg;

    // Branch kind held per slot
    typedef enum logic [1:0] {
        BRK_COND = 2'b00,
        BRK_JUMP = 2'b01,
        BRK_RET  = 2'b10,
        BRK_RSVD = 2'b11
    } brk_e;

    typedef struct packed {
        logic vld;
        brk_e kind;
    } slot_t;

    localparam int NUM_SLOTS = 3;
    localparam int NUM_TGTS  = 6;

    // Target positions inside a line
    localparam int TGT_T  = 0;
    localparam int TGT_N  = 1;
    localparam int TGT_TT = 2;
    localparam int TGT_TN = 3;
    localparam int TGT_NT = 4;
    localparam int TGT_NN = 5;

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_SERVE = 1'b1
    } ctl_e;

endpackage

// File: rtl/spc_store.sv
module spc_store
    import spc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int TAG_W  = 23,
    parameter int IDX_W  = 4
) (
    input  logic                                clk,
    input  logic                                clr_en,
    input  logic [IDX_W-1:0]                    clr_idx,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [TAG_W-1:0]                    wr_tag,
    input  slot_t [NUM_SLOTS-1:0]               wr_slots,
    input  logic [NUM_TGTS-1:0][ADDR_W-1:0]     wr_tgts,
    input  logic [IDX_W-1:0]                    rd_idx,
    output logic                                rd_vld,
    output logic [TAG_W-1:0]                    rd_tag,
    output slot_t [NUM_SLOTS-1:0]               rd_slots,
    output logic [NUM_TGTS-1:0][ADDR_W-1:0]     rd_tgts
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]                   vld_q;
    logic [TAG_W-1:0]                   tag_q  [DEPTH];
    slot_t [NUM_SLOTS-1:0]              slot_q [DEPTH];
    logic [NUM_TGTS-1:0][ADDR_W-1:0]    tgt_q  [DEPTH];

    // Line valid flags: clearing outranks filling
    always_ff @(posedge clk) begin
        if (clr_en) begin
            vld_q[clr_idx] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Payload
    always_ff @(posedge clk) begin
        if (wr_en && !clr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            slot_q[wr_idx] <= wr_slots;
            tgt_q[wr_idx]  <= wr_tgts;
        end
    end

    always_comb begin
        rd_vld   = vld_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_slots = slot_q[rd_idx];
        rd_tgts  = tgt_q[rd_idx];
    end

endmodule

// File: rtl/spc_dir_pick.sv
module spc_dir_pick
    import spc_pkg::*;
(
    input  logic  hit,
    input  slot_t slot,
    input  logic  pred,
    output logic  follow,
    output logic  taken
);

    logic forced;

    always_comb begin
        follow = hit && slot.vld;
        unique case (slot.kind)
            BRK_JUMP, BRK_RET:  forced = 1'b1;
            BRK_COND, BRK_RSVD: forced = 1'b0;
            default:            forced = 1'b0;
        endcase
        taken = follow && (forced || pred);
    end

endmodule

// File: rtl/succ_path_cache.sv
module succ_path_cache
    import spc_pkg::*;
#(
    parameter int ADDR_W   = 30,
    parameter int TAG_W    = 23,
    parameter int IDX_W    = 4,
    parameter int SEQ_STEP = 4,
    localparam int OFS_W   = ADDR_W - TAG_W - IDX_W,
    localparam int LINE_W  = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_pred1,
    input  logic              lk_pred2,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_next1,
    output logic [ADDR_W-1:0] lk_next2,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [2:0]        wr_slot_vld,
    input  logic [5:0]        wr_slot_kind,
    input  logic [ADDR_W-1:0] wr_tgt_t,
    input  logic [ADDR_W-1:0] wr_tgt_n,
    input  logic [ADDR_W-1:0] wr_tgt_tt,
    input  logic [ADDR_W-1:0] wr_tgt_tn,
    input  logic [ADDR_W-1:0] wr_tgt_nt,
    input  logic [ADDR_W-1:0] wr_tgt_nn
);

    localparam int               DEPTH    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(SEQ_STEP);

    // ---------------- controller ----------------
    ctl_e             st_q, st_d;
    logic [IDX_W-1:0] sweep_ptr_q;
    logic             sweeping, serving, wr_fire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_SWEEP;
            sweep_ptr_q <= '0;
        end else begin
            st_q <= st_d;
            if (sweeping) sweep_ptr_q <= sweep_ptr_q + 1'b1;
        end
    end

    always_comb begin
        st_d     = st_q;
        sweeping = 1'b0;
        serving  = 1'b0;
        unique case (st_q)
            ST_SWEEP: begin
                sweeping = 1'b1;
                if (sweep_ptr_q == LAST_IDX) st_d = ST_SERVE;  // SWEEP_DONE
            end
            ST_SERVE: begin
                serving = 1'b1;
            end
            default: st_d = ST_SWEEP;
        endcase
        wr_fire = serving && wr_en;
    end

    // ---------------- write packing ----------------
    slot_t [NUM_SLOTS-1:0]           wr_slots;
    logic [NUM_TGTS-1:0][ADDR_W-1:0] wr_tgts;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign wr_slots[k].vld  = wr_slot_vld[k];
        assign wr_slots[k].kind = brk_e'(wr_slot_kind[2*k +: 2]);
    end

    always_comb begin
        wr_tgts[TGT_T]  = wr_tgt_t;
        wr_tgts[TGT_N]  = wr_tgt_n;
        wr_tgts[TGT_TT] = wr_tgt_tt;
        wr_tgts[TGT_TN] = wr_tgt_tn;
        wr_tgts[TGT_NT] = wr_tgt_nt;
        wr_tgts[TGT_NN] = wr_tgt_nn;
    end

    // ---------------- storage ----------------
    logic [IDX_W-1:0]                lk_idx;
    logic [TAG_W-1:0]                lk_tag;
    logic                            rd_vld;
    logic [TAG_W-1:0]                rd_tag;
    slot_t [NUM_SLOTS-1:0]           rd_slots;
    logic [NUM_TGTS-1:0][ADDR_W-1:0] rd_tgts;

    assign lk_idx = lk_addr[OFS_W +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];

    spc_store #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W),
        .IDX_W  (IDX_W)
    ) store_i (
        .clk      (clk),
        .clr_en   (sweeping),
        .clr_idx  (sweep_ptr_q),
        .wr_en    (wr_fire),
        .wr_idx   (wr_line[IDX_W-1:0]),
        .wr_tag   (wr_line[LINE_W-1 -: TAG_W]),
        .wr_slots (wr_slots),
        .wr_tgts  (wr_tgts),
        .rd_idx   (lk_idx),
        .rd_vld   (rd_vld),
        .rd_tag   (rd_tag),
        .rd_slots (rd_slots),
        .rd_tgts  (rd_tgts)
    );

    // ---------------- two-level selection ----------------
    logic  hit;
    logic  follow1, take1, follow2, take2;
    slot_t slot_b;
    logic [ADDR_W-1:0] seq1, seq2, pick1, pick2;

    assign hit = serving && rd_vld && (rd_tag == lk_tag);

    spc_dir_pick lvl1_i (
        .hit    (hit),
        .slot   (rd_slots[0]),
        .pred   (lk_pred1),
        .follow (follow1),
        .taken  (take1)
    );

    assign slot_b = take1 ? rd_slots[1] : rd_slots[2];

    spc_dir_pick lvl2_i (
        .hit    (hit),
        .slot   (slot_b),
        .pred   (lk_pred2),
        .follow (follow2),
        .taken  (take2)
    );

    always_comb begin
        seq1  = lk_addr + STEP_A;
        pick1 = take1 ? rd_tgts[TGT_T] : rd_tgts[TGT_N];
        lk_next1 = follow1 ? pick1 : seq1;
        seq2  = lk_next1 + STEP_A;
        unique case ({take1, take2})
            2'b11:   pick2 = rd_tgts[TGT_TT];
            2'b10:   pick2 = rd_tgts[TGT_TN];
            2'b01:   pick2 = rd_tgts[TGT_NT];
            default: pick2 = rd_tgts[TGT_NN];
        endcase
        lk_next2 = follow2 ? pick2 : seq2;
        lk_hit   = hit;
    end

    // ---------------- assertions ----------------
    // R1
    sweep_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SWEEP) |-> !lk_hit);

    // R1
    sweep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SWEEP && sweep_ptr_q != LAST_IDX) |=> (st_q == ST_SWEEP));

    // R3
    miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_next1 == lk_addr + STEP_A) &&
                    (lk_next2 == lk_addr + STEP_A + STEP_A));

    // R5
    forced_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && rd_slots[0].vld &&
         (rd_slots[0].kind == BRK_JUMP || rd_slots[0].kind == BRK_RET))
        |-> (lk_next1 == rd_tgts[TGT_T]));

    // R9
    second_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !rd_slots[0].vld && !rd_slots[2].vld)
        |-> (lk_next2 == lk_addr + STEP_A + STEP_A));

    // R10
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (lk_addr[ADDR_W-1:OFS_W] != $past(wr_line)) || lk_hit);

endmodule

// File: tb/succ_path_cache_tb_top.sv
module succ_path_cache_tb_top;

    localparam int AW = 30;
    localparam int LW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_pred1 = 1'b0, lk_pred2 = 1'b0;
    logic          lk_hit;
    logic [AW-1:0] lk_next1, lk_next2;
    logic          wr_en = 1'b0;
    logic [LW-1:0] wr_line = '0;
    logic [2:0]    wr_slot_vld = '0;
    logic [5:0]    wr_slot_kind = '0;
    logic [AW-1:0] wr_tgt_t = '0, wr_tgt_n = '0, wr_tgt_tt = '0;
    logic [AW-1:0] wr_tgt_tn = '0, wr_tgt_nt = '0, wr_tgt_nn = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    succ_path_cache dut_i (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_pred1(lk_pred1),
        .lk_pred2(lk_pred2), .lk_hit(lk_hit), .lk_next1(lk_next1),
        .lk_next2(lk_next2), .wr_en(wr_en), .wr_line(wr_line),
        .wr_slot_vld(wr_slot_vld), .wr_slot_kind(wr_slot_kind),
        .wr_tgt_t(wr_tgt_t), .wr_tgt_n(wr_tgt_n), .wr_tgt_tt(wr_tgt_tt),
        .wr_tgt_tn(wr_tgt_tn), .wr_tgt_nt(wr_tgt_nt), .wr_tgt_nn(wr_tgt_nn)
    );

    localparam logic [AW-1:0] T0 = 30'h0001000, N0 = 30'h0002000;
    localparam logic [AW-1:0] TT0 = 30'h0003000, TN0 = 30'h0004000;
    localparam logic [AW-1:0] NT0 = 30'h0005000, NN0 = 30'h0006000;
    localparam logic [22:0]   TAG_A = 23'h00ABC, TAG_B = 23'h012F0;

    function automatic logic [AW-1:0] mk(logic [22:0] tag, logic [3:0] idx, logic [2:0] ofs);
        return {tag, idx, ofs};
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_fields(logic [22:0] tag, logic [3:0] idx, logic [2:0] vld,
                              logic [5:0] kind, logic [AW-1:0] base);
        wr_line = {tag, idx}; wr_slot_vld = vld; wr_slot_kind = kind;
        wr_tgt_t = T0 + base; wr_tgt_n = N0 + base; wr_tgt_tt = TT0 + base;
        wr_tgt_tn = TN0 + base; wr_tgt_nt = NT0 + base; wr_tgt_nn = NN0 + base;
    endtask

    task automatic fill(logic [22:0] tag, logic [3:0] idx, logic [2:0] vld,
                        logic [5:0] kind, logic [AW-1:0] base);
        @(negedge clk);
        put_fields(tag, idx, vld, kind, base);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(logic [AW-1:0] a, logic p1, logic p2);
        @(negedge clk);
        lk_addr = a; lk_pred1 = p1; lk_pred2 = p2;
        #2;
    endtask

    task automatic expect3(string req, logic h, logic [AW-1:0] e1, logic [AW-1:0] e2);
        chk({req, " hit"}, AW'(lk_hit), AW'(h));
        chk({req, " next1"}, lk_next1, e1);
        chk({req, " next2"}, lk_next2, e2);
    endtask

    task automatic t_reset_state();
        lk_addr = mk(TAG_A, 4'd1, 3'd0);
        #2;
        expect3("R1 in reset", 1'b0, lk_addr + 4, lk_addr + 8);
    endtask

    task automatic t_sweep_drop();
        logic [AW-1:0] a;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        a = mk(TAG_A, 4'd0, 3'd0);
        put_fields(TAG_A, 4'd0, 3'b111, 6'b000000, '0);
        wr_en = 1'b1;
        lk_addr = a;
        #2;
        expect3("R1 sweep lookup", 1'b0, a + 4, a + 8);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (10) @(negedge clk);
        look(a, 1'b1, 1'b1);
        expect3("R1 write during sweep dropped", 1'b0, a + 4, a + 8);
    endtask

    task automatic t_miss_wrap();
        look(30'h3FFFFFFE, 1'b1, 1'b1);
        expect3("R3 miss wrap", 1'b0, 30'h2, 30'h6);
    endtask

    task automatic t_cond_paths();
        logic [AW-1:0] a;
        a = mk(TAG_A, 4'd1, 3'd0);
        fill(TAG_A, 4'd1, 3'b111, 6'b000000, '0);
        look(a, 1'b1, 1'b1); expect3("R4 R7 TT", 1'b1, T0, TT0);
        look(a, 1'b1, 1'b0); expect3("R4 R7 TN", 1'b1, T0, TN0);
        look(a, 1'b0, 1'b1); expect3("R4 R7 NT", 1'b1, N0, NT0);
        look(a, 1'b0, 1'b0); expect3("R4 R7 NN", 1'b1, N0, NN0);
    endtask

    task automatic t_tag_match();
        look(mk(TAG_B, 4'd1, 3'd0), 1'b1, 1'b1);
        expect3("R2 tag mismatch", 1'b0, mk(TAG_B, 4'd1, 3'd4), mk(TAG_B, 4'd2, 3'd0));
        look(mk(TAG_A, 4'd1, 3'd5), 1'b1, 1'b1);
        expect3("R2 offset ignored", 1'b1, T0, TT0);
    endtask

    task automatic t_forced_first();
        fill(TAG_A, 4'd2, 3'b111, 6'b000001, '0);
        look(mk(TAG_A, 4'd2, 3'd0), 1'b0, 1'b0);
        expect3("R5 jump first", 1'b1, T0, TN0);
        fill(TAG_A, 4'd3, 3'b111, 6'b000010, '0);
        look(mk(TAG_A, 4'd3, 3'd0), 1'b0, 1'b1);
        expect3("R5 return first", 1'b1, T0, TT0);
    endtask

    task automatic t_first_invalid();
        logic [AW-1:0] a;
        a = mk(TAG_A, 4'd4, 3'd0);
        fill(TAG_A, 4'd4, 3'b110, 6'b000000, '0);
        look(a, 1'b1, 1'b1);
        expect3("R6 first slot invalid", 1'b1, a + 4, NT0);
    endtask

    task automatic t_forced_second();
        fill(TAG_A, 4'd5, 3'b111, 6'b100100, '0);
        look(mk(TAG_A, 4'd5, 3'd0), 1'b1, 1'b0);
        expect3("R8 jump second", 1'b1, T0, TT0);
        look(mk(TAG_A, 4'd5, 3'd0), 1'b0, 1'b0);
        expect3("R8 return second", 1'b1, N0, NT0);
    endtask

    task automatic t_second_invalid();
        fill(TAG_A, 4'd6, 3'b001, 6'b000000, '0);
        look(mk(TAG_A, 4'd6, 3'd0), 1'b1, 1'b1);
        expect3("R9 taken side seq", 1'b1, T0, T0 + 4);
        look(mk(TAG_A, 4'd6, 3'd0), 1'b0, 1'b1);
        expect3("R9 not-taken side seq", 1'b1, N0, N0 + 4);
    endtask

    task automatic t_rsvd_kind();
        fill(TAG_A, 4'd7, 3'b111, 6'b111111, '0);
        look(mk(TAG_A, 4'd7, 3'd0), 1'b0, 1'b0);
        expect3("R11 kind 11 not taken", 1'b1, N0, NN0);
        look(mk(TAG_A, 4'd7, 3'd0), 1'b1, 1'b0);
        expect3("R11 kind 11 taken", 1'b1, T0, TN0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        put_fields(TAG_A, 4'd1, 3'b111, 6'b000000, 30'h0000100);
        wr_en = 1'b1;
        lk_addr = mk(TAG_A, 4'd1, 3'd0); lk_pred1 = 1'b1; lk_pred2 = 1'b0;
        #2;
        expect3("R10 same-cycle old", 1'b1, T0, TN0);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        expect3("R10 next-cycle new", 1'b1, T0 + 30'h100, TN0 + 30'h100);
    endtask

    task automatic t_overwrite_tag();
        fill(TAG_A, 4'd8, 3'b111, 6'b000000, '0);
        fill(TAG_B, 4'd8, 3'b111, 6'b000000, 30'h0000200);
        look(mk(TAG_A, 4'd8, 3'd0), 1'b1, 1'b1);
        expect3("R10 old tag gone", 1'b0, mk(TAG_A, 4'd8, 3'd4), mk(TAG_A, 4'd9, 3'd0));
        look(mk(TAG_B, 4'd8, 3'd0), 1'b1, 1'b1);
        expect3("R10 new tag hits", 1'b1, T0 + 30'h200, TT0 + 30'h200);
    endtask

    initial begin
        t_reset_state();
        t_sweep_drop();
        t_miss_wrap();
        t_cond_paths();
        t_tag_match();
        t_forced_first();
        t_first_invalid();
        t_forced_second();
        t_second_invalid();
        t_rsvd_kind();
        t_collide();
        t_overwrite_tag();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule